// File: doc/BRIEF.md
# Two-Wire Configuration Memory Page Programmer

This block is the master side of a programming sequence that fills a serial configuration memory over a two-wire bus. A single `go` pulse lowers the programming-select output, then writes the memory one page at a time. Each page is one message: a start condition, the write device code, a 24-bit memory address and one page of data bytes taken from a byte stream with a valid/ready handshake, then a stop condition. Every byte on the bus is followed by an acknowledge slot. In that slot the master releases the data line and the memory pulls it low.

After the last page the block sends a start condition and the check device code 0xA7. When that byte is acknowledged, the block raises the programming-select output again and sets `done`. If any byte is not acknowledged, the block sends a stop condition, releases the data line, raises the select output, sets `error` and goes back to idle. A clock-enable input sets the pace of the bus. The bus moves by at most one quarter-bit step per cycle in which `tick` is high. The data line is open drain: the block only ever pulls it low, and it reads the level of the line on a separate input.

Top module: `cfgw_page_writer`

## Requirements
- R1: After reset the block holds `ser_en_n` at 1, `scl_o` at 1 and `sda_pull_o` at 0. It holds `in_ready`, `done` and `error` at 0.
- R2: A `go` pulse while idle drives `ser_en_n` to 0. The output stays 0 for every bus event of the sequence and returns to 1 once the block has set `done` or `error`.
- R3: Every message opens with a start condition, in which the data line falls while `scl_o` is high. Each page message closes with a stop condition, in which the data line rises while `scl_o` is high. At all other times the data line changes only while `scl_o` is low.
- R4: A page message sends the device byte 0xA6 first, then three address bytes. The device byte and the address bytes go out most significant bit first.
- R5: The address of page p is p times PAGE_BYTES, which is p shifted left by log2(PAGE_BYTES), in a 24-bit field. The most significant byte is sent first. Pages go out in order from 0 to PAGES-1.
- R6: Each page carries exactly PAGE_BYTES data bytes. The block takes one byte from the input stream for each cycle in which `in_valid` and `in_ready` are both high, and sends it least significant bit first.
- R7: In the ninth bit of every byte, the master leaves the data line released. A low level sampled while the clock is high in that bit counts as an acknowledge.
- R8: After the last page, the block sends a start condition and the byte 0xA7. When that byte is acknowledged, the block sets `done`.
- R9: A missing acknowledge on any byte aborts the sequence. The block sends no further bytes, issues a stop condition, leaves the data line released and sets `error`. `done` stays at 0.
- R10: `done` and `error` are never both set. Each holds its value until the next `go`, and `go` clears both.
- R11: The bus outputs `scl_o` and `sda_pull_o` change only in the cycle after a cycle in which `tick` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Clock enable that paces the bus in quarter-bit steps |
| go | input | 1 | Starts a full programming sequence when the block is idle |
| in_valid | input | 1 | A data byte is present on `in_data` |
| in_data | input | 8 | Next data byte to write |
| in_ready | output | 1 | Block accepts `in_data` in this cycle |
| ser_en_n | output | 1 | Programming-mode select, low while the sequence runs |
| scl_o | output | 1 | Bus clock |
| sda_pull_o | output | 1 | 1 pulls the open-drain data line low |
| sda_i | input | 1 | Level of the data line |
| done | output | 1 | Sequence finished with every byte acknowledged |
| error | output | 1 | Sequence aborted on a missing acknowledge |

## Verification
On every cycle, the assertions check the bus shape: the data line is steady while the clock is high during a byte, a fall with the clock high occurs only inside a start, and a rise with the clock high occurs only inside a stop. They also check that bus outputs are frozen without a tick, that the select output matches activity, that the two flags exclude each other, and that a missing acknowledge leads straight to the abort step. The byte content can only be shown by the bench, which decodes the bus as a responding memory would. That content covers the device codes, the page addresses, the bit order of data against address bytes, the number of bytes per page and the final check byte. The bench also shows where an abort stops the traffic, by refusing the acknowledge at chosen address, data and final bytes.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

  typedef enum logic [1:0] {OP_NONE, OP_START, OP_STOP, OP_BYTE} bus_op_e;

  localparam logic [7:0] DEV_WRITE = 8'hA6;
  localparam logic [7:0] DEV_CHECK = 8'hA7;

  // memory address of a page: page index moved up by the page size exponent
  function automatic logic [23:0] page_addr(input logic [23:0] page, input int unsigned shift);
    return page << shift;
  endfunction

  // address byte select, index 0 is the most significant byte
  function automatic logic [7:0] addr_byte(input logic [23:0] addr, input logic [1:0] idx);
    case (idx)
      2'd0:    return addr[23:16];
      2'd1:    return addr[15:8];
      default: return addr[7:0];
    endcase
  endfunction

  // bit n of the wire order of a byte
  function automatic logic wire_bit(input logic [7:0] b, input logic [2:0] n, input logic lsb_first);
    return lsb_first ? b[n] : b[3'd7 - n];
  endfunction

endpackage

// File: rtl/cfgw_bit_engine.sv
module cfgw_bit_engine
  import cfgw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cmd_valid,
  input  bus_op_e    cmd_op,
  input  logic [7:0] cmd_byte,
  input  logic       cmd_lsb,
  input  logic       sda_i,
  output logic       busy,
  output logic       done,
  output logic       nack,
  output logic       scl,
  output logic       sda_pull
);

  bus_op_e    op_r;
  logic [1:0] q_r;
  logic [3:0] bit_r;
  logic [7:0] sh_r;
  logic       lsb_r, scl_r, pull_r, done_r, nack_r;

  wire ack_slot = (bit_r == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_r <= OP_NONE; q_r <= 2'd0; bit_r <= 4'd0; sh_r <= 8'd0; lsb_r <= 1'b0;
      scl_r <= 1'b1; pull_r <= 1'b0; done_r <= 1'b0; nack_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (op_r == OP_NONE) begin
        if (cmd_valid) begin
          op_r <= cmd_op; q_r <= 2'd0; bit_r <= 4'd0;
          sh_r <= cmd_byte; lsb_r <= cmd_lsb; nack_r <= 1'b0;
        end
      end else if (tick) begin
        q_r <= q_r + 2'd1;
        unique case (op_r)
          OP_START: begin
            case (q_r)
              2'd0:    begin scl_r <= 1'b1; pull_r <= 1'b0; end
              2'd1:    pull_r <= 1'b1;
              default: begin scl_r <= 1'b0; op_r <= OP_NONE; done_r <= 1'b1; end
            endcase
          end
          OP_STOP: begin
            case (q_r)
              2'd0:    pull_r <= 1'b1;
              2'd1:    scl_r <= 1'b1;
              default: begin pull_r <= 1'b0; op_r <= OP_NONE; done_r <= 1'b1; end
            endcase
          end
          OP_BYTE: begin
            case (q_r)
              2'd0: pull_r <= ack_slot ? 1'b0 : ~wire_bit(sh_r, bit_r[2:0], lsb_r);
              2'd1: scl_r <= 1'b1;
              2'd2: if (ack_slot) nack_r <= sda_i;
              default: begin
                scl_r <= 1'b0;
                if (ack_slot) begin op_r <= OP_NONE; done_r <= 1'b1; end
                else bit_r <= bit_r + 4'd1;
              end
            endcase
          end
          default: op_r <= OP_NONE;
        endcase
      end
    end
  end

  assign busy     = (op_r != OP_NONE);
  assign done     = done_r;
  assign nack     = nack_r;
  assign scl      = scl_r;
  assign sda_pull = pull_r;

  // bus lines move only after a tick
  p_bus_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(scl_r) && $stable(pull_r)));

  // data held while the clock is high inside a byte
  p_data_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_r == OP_BYTE && scl_r) |=> (!scl_r || $stable(pull_r)));

  // data falling with clock high only as a start
  p_fall_is_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_r && $past(scl_r) && $rose(pull_r)) |-> ($past(op_r) == OP_START));

  // data rising with clock high only as a stop
  p_rise_is_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_r && $past(scl_r) && $fell(pull_r)) |-> ($past(op_r) == OP_STOP));

  // line released for the acknowledge bit
  p_ack_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_r == OP_BYTE && ack_slot && scl_r) |-> !pull_r);

endmodule

// File: rtl/cfgw_page_writer.sv
module cfgw_page_writer
  import cfgw_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int PAGES      = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       go,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       ser_en_n,
  output logic       scl_o,
  output logic       sda_pull_o,
  input  logic       sda_i,
  output logic       done,
  output logic       error
);

  localparam int unsigned SHIFT = $clog2(PAGE_BYTES);
  localparam int BW = $clog2(PAGE_BYTES + 1);
  localparam int PW = $clog2(PAGES + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_DEV, ST_ADDR, ST_DATA, ST_STOP,
    ST_FIN_START, ST_FIN_DEV, ST_ABORT
  } seq_e;

  seq_e          st;
  logic [PW-1:0] page_cnt;
  logic [BW-1:0] byte_cnt;
  logic [1:0]    a_idx;
  logic          pend_r, ser_n_r, done_r, err_r;

  logic       need, cmd_valid, cmd_lsb;
  bus_op_e    cmd_op;
  logic [7:0] cmd_byte;
  logic       eng_busy, eng_done, eng_nack;

  always_comb begin
    need = 1'b1; cmd_op = OP_BYTE; cmd_byte = 8'd0; cmd_lsb = 1'b0;
    case (st)
      ST_START, ST_FIN_START: cmd_op = OP_START;
      ST_DEV:     cmd_byte = DEV_WRITE;
      ST_ADDR:    cmd_byte = addr_byte(page_addr(24'(page_cnt), SHIFT), a_idx);
      ST_DATA:    begin need = in_valid; cmd_byte = in_data; cmd_lsb = 1'b1; end
      ST_STOP, ST_ABORT: cmd_op = OP_STOP;
      ST_FIN_DEV: cmd_byte = DEV_CHECK;
      default:    need = 1'b0;
    endcase
  end

  assign cmd_valid = need && !pend_r && !eng_busy;
  assign in_ready  = (st == ST_DATA) && !pend_r && !eng_busy;

  wire in_byte_state = (st == ST_DEV) || (st == ST_ADDR) || (st == ST_DATA) || (st == ST_FIN_DEV);
  wire byte_nack_ev  = eng_done && eng_nack && in_byte_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; page_cnt <= '0; byte_cnt <= '0; a_idx <= 2'd0;
      pend_r <= 1'b0; ser_n_r <= 1'b1; done_r <= 1'b0; err_r <= 1'b0;
    end else begin
      if (go && st == ST_IDLE) begin
        st <= ST_START; page_cnt <= '0; ser_n_r <= 1'b0;
        done_r <= 1'b0; err_r <= 1'b0;
      end
      if (cmd_valid) pend_r <= 1'b1;
      if (eng_done) begin
        pend_r <= 1'b0;
        if (byte_nack_ev) st <= ST_ABORT;
        else begin
          case (st)
            ST_START: begin st <= ST_DEV; byte_cnt <= '0; a_idx <= 2'd0; end
            ST_DEV:   st <= ST_ADDR;
            ST_ADDR:  if (a_idx == 2'd2) st <= ST_DATA; else a_idx <= a_idx + 2'd1;
            ST_DATA:  if (byte_cnt == BW'(PAGE_BYTES - 1)) st <= ST_STOP;
                      else byte_cnt <= byte_cnt + 1'b1;
            ST_STOP:  if (page_cnt == PW'(PAGES - 1)) st <= ST_FIN_START;
                      else begin page_cnt <= page_cnt + 1'b1; st <= ST_START; end
            ST_FIN_START: st <= ST_FIN_DEV;
            ST_FIN_DEV:   begin st <= ST_IDLE; done_r <= 1'b1; ser_n_r <= 1'b1; end
            ST_ABORT:     begin st <= ST_IDLE; err_r <= 1'b1; ser_n_r <= 1'b1; end
            default:      st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  cfgw_bit_engine u_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_lsb(cmd_lsb),
    .sda_i(sda_i), .busy(eng_busy), .done(eng_done), .nack(eng_nack),
    .scl(scl_o), .sda_pull(sda_pull_o)
  );

  assign ser_en_n = ser_n_r;
  assign done     = done_r;
  assign error    = err_r;

  // programming select low exactly while a sequence runs
  p_select_tracks_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |-> !ser_en_n);
  p_select_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> ser_en_n);

  // outcome flags exclude each other
  p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  // a refused byte goes straight to the abort stop
  p_nack_aborts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_nack_ev |=> (st == ST_ABORT));

  // an accepted stream byte starts a bus byte at once
  p_handshake_starts_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> eng_busy);

  // page counter stays inside the device
  p_page_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    page_cnt <= PW'(PAGES - 1));

endmodule

// File: tb/cfgw_page_writer_test.sv
module cfgw_page_writer_test;
  localparam int PB = 4;
  localparam int NP = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, go = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic slave_pull = 1'b0, tick_en = 1'b1;
  wire in_ready, ser_en_n, scl_o, sda_pull_o, done, error;
  wire sda_line = !(sda_pull_o || slave_pull);

  cfgw_page_writer #(.PAGE_BYTES(PB), .PAGES(NP)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .ser_en_n(ser_en_n), .scl_o(scl_o), .sda_pull_o(sda_pull_o), .sda_i(sda_line),
    .done(done), .error(error)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] mem [NP*PB];
  int feed_idx = 0, feed_on = 0;
  bit prev_hs = 0;
  int starts = 0, stops = 0, bytes_seen = 0, msg = 0, byten = 0, bitn = 0;
  int nack_msg = -1, nack_byte = -1;
  bit ack_now = 1;
  logic [7:0] wbits;
  logic pscl = 1'b1, psda = 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_byte(input int m, input int b);
    int a;
    a = m * PB;
    if (m == NP) return 8'hA7;
    if (b == 0) return 8'hA6;
    if (b == 1) return (a / 65536) % 256;
    if (b == 2) return (a / 256) % 256;
    if (b == 3) return a % 256;
    return int'(mem[m*PB + b - 4]);
  endfunction

  // tick source and stream feeder
  always @(negedge clk) begin
    tick <= tick_en && ($urandom_range(0, 2) != 0);
    if (prev_hs) feed_idx++;
    in_valid = (feed_on != 0) && (feed_idx < NP*PB) && ($urandom_range(0, 3) != 0);
    in_data  = (feed_idx < NP*PB) ? mem[feed_idx] : 8'h00;
    prev_hs  = in_valid && in_ready;
  end

  // bus decoder acting as the memory
  always @(negedge clk) begin
    logic s, d;
    int val_msb, val_lsb, ex;
    s = scl_o; d = sda_line;
    if (pscl && s && psda && !d) begin
      starts++; msg = starts - 1; byten = 0; bitn = 0;
      check(ser_en_n == 1'b0, "R2 select low at start", ser_en_n, 0);
    end else if (pscl && s && !psda && d) begin
      stops++;
    end else if (pscl && s && psda != d) begin
      check(0, "R3 data moved with clock high", d, psda);
    end
    if (!pscl && s) begin
      if (bitn < 8) wbits[bitn] = d;
      if (bitn == 8) check(sda_pull_o == 1'b0, "R7 master releases ack bit", sda_pull_o, 0);
      bitn++;
      if (bitn == 8) begin
        bytes_seen++;
        val_msb = 0; val_lsb = 0;
        for (int i = 0; i < 8; i++) begin
          val_msb = val_msb * 2 + int'(wbits[i]);
          val_lsb = val_lsb + (int'(wbits[i]) << i);
        end
        ex = exp_byte(msg, byten);
        if (msg == NP)
          check(byten == 0 && val_msb == ex, "R8 check device byte", val_msb, ex);
        else if (byten > 3 + PB)
          check(0, "R6 too many bytes in page", byten, 3 + PB);
        else if (byten == 0)
          check(val_msb == ex, "R4 write device byte", val_msb, ex);
        else if (byten <= 3)
          check(val_msb == ex, "R5 address byte", val_msb, ex);
        else
          check(val_lsb == ex, "R6 data byte lsb first", val_lsb, ex);
        ack_now = !(msg == nack_msg && byten == nack_byte);
      end
    end
    if (pscl && !s) begin
      if (bitn == 8) slave_pull = ack_now;
      else if (bitn == 9) begin slave_pull = 1'b0; bitn = 0; byten++; end
    end
    pscl = s; psda = d;
  end

  task automatic run_seq(input int nm, input int nb, output bit finished);
    int cyc;
    nack_msg = nm; nack_byte = nb;
    starts = 0; stops = 0; bytes_seen = 0; bitn = 0;
    feed_idx = 0; prev_hs = 0; feed_on = 1;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    check(done == 1'b0 && error == 1'b0, "R10 go clears flags", {done, error}, 0);
    check(ser_en_n == 1'b0, "R2 select low after go", ser_en_n, 0);
    cyc = 0;
    while (!done && !error && cyc < 40000) begin @(negedge clk); cyc++; end
    finished = (cyc < 40000);
    check(finished, "R8 watchdog", cyc, 40000);
    repeat (20) @(negedge clk);
    feed_on = 0;
  endtask

  initial begin
    bit fin;
    logic s0, p0;
    int b0;
    void'($urandom(32'd4711));
    for (int i = 0; i < NP*PB; i++) mem[i] = 8'($urandom_range(0, 255));
    repeat (3) @(negedge clk);
    check(ser_en_n == 1 && scl_o == 1 && sda_pull_o == 0, "R1 bus idle in reset", {ser_en_n, scl_o, sda_pull_o}, 3'b110);
    check(in_ready == 0 && done == 0 && error == 0, "R1 flags in reset", {in_ready, done, error}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ser_en_n == 1 && scl_o == 1 && sda_pull_o == 0 && in_ready == 0, "R1 idle after reset", {ser_en_n, scl_o, sda_pull_o, in_ready}, 4'b1100);

    // full write, every byte acknowledged
    run_seq(-1, -1, fin);
    check(done == 1 && error == 0, "R8 done after full write", {done, error}, 2'b10);
    check(ser_en_n == 1, "R2 select high at end", ser_en_n, 1);
    check(starts == NP + 1, "R3 start count", starts, NP + 1);
    check(stops == NP, "R3 stop count", stops, NP);
    check(feed_idx == NP*PB, "R6 bytes taken from stream", feed_idx, NP*PB);
    check(bytes_seen == NP*(4+PB) + 1, "R5 bytes on bus", bytes_seen, NP*(4+PB) + 1);
    repeat (100) @(negedge clk);
    check(done == 1 && error == 0, "R10 done holds", {done, error}, 2'b10);

    // refused address byte in second page
    run_seq(1, 2, fin);
    check(error == 1 && done == 0, "R9 error on address nack", {done, error}, 2'b01);
    check(stops == 2, "R9 stop after abort", stops, 2);
    check(bytes_seen == (4+PB) + 3, "R9 traffic ends at refused byte", bytes_seen, (4+PB) + 3);
    check(sda_pull_o == 0 && ser_en_n == 1, "R9 line released and select high", {sda_pull_o, ser_en_n}, 2'b01);
    b0 = bytes_seen;
    repeat (200) @(negedge clk);
    check(bytes_seen == b0 && error == 1, "R10 error holds, no more bytes", bytes_seen, b0);

    // refused data byte in first page
    run_seq(0, 5, fin);
    check(error == 1 && done == 0, "R9 error on data nack", {done, error}, 2'b01);
    check(bytes_seen == 6 && stops == 1, "R9 abort after data byte", bytes_seen, 6);
    check(feed_idx == 2, "R6 stream stops at abort", feed_idx, 2);

    // refused final check byte
    run_seq(NP, 0, fin);
    check(error == 1 && done == 0, "R9 error on final nack", {done, error}, 2'b01);
    check(stops == NP + 1, "R9 stop after final nack", stops, NP + 1);

    // fresh data, with a pause in the tick stream
    for (int i = 0; i < NP*PB; i++) mem[i] = 8'($urandom_range(0, 255));
    nack_msg = -1; nack_byte = -1;
    starts = 0; stops = 0; bytes_seen = 0; bitn = 0;
    feed_idx = 0; prev_hs = 0; feed_on = 1;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    repeat (300) @(negedge clk);
    tick_en = 1'b0;
    repeat (2) @(negedge clk);
    s0 = scl_o; p0 = sda_pull_o;
    repeat (50) @(negedge clk);
    check(scl_o == s0 && sda_pull_o == p0, "R11 bus frozen without tick", {scl_o, sda_pull_o}, {s0, p0});
    tick_en = 1'b1;
    b0 = 0;
    while (!done && !error && b0 < 40000) begin @(negedge clk); b0++; end
    check(done == 1 && error == 0, "R8 done after paused run", {done, error}, 2'b10);
    check(bytes_seen == NP*(4+PB) + 1, "R6 bytes after paused run", bytes_seen, NP*(4+PB) + 1);
    feed_on = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule